// File: doc/BRIEF.md
# Flash Block Protection and Interrupt Unit

This unit sits in front of an on-chip flash array that is split into fixed-size protection blocks of 16 KB. Every request carries an address and a kind: instruction fetch, data read, debug read, program or erase. The unit picks out the protection block from the address and checks two rights for that block. One is a read right, which covers data and debug reads. The other is a write right, which covers program and erase. Fetches are always served, so a block whose read right is cleared runs as execute-only code. A refused read returns zeros together with a one-cycle error flag.

Program and erase commands that pass the check start a short busy sequence of fixed length. A pump voltage fault during that sequence ends it at once. The unit keeps three sticky raw interrupt flags: operation finished, access refused and pump voltage fault. Software clears them by writing 1s. A mask register selects which flags drive the single interrupt line. The protection rights can only be taken away at run time, and they all return only on reset. The flash cells and the charge pump are outside the unit: the array is read combinationally through an address/data pair, and the pump fault arrives as an input.

Top module: `flash_guard`

## Requirements
- R1: After reset, every read right and write right is 1, the raw flags (bit 0 finished, bit 1 access refused, bit 2 pump fault) are 0, the mask is 0, `busy` is 0, `irq` is 0 and no response is valid.
- R2: A write to the read rights (`prot_sel`=0) or the write rights (`prot_sel`=1) replaces them with the old value ANDed with `prot_wdata`, so a right can go from 1 to 0 but never from 0 to 1.
- R3: An instruction fetch (kind 0) is always served with the array word at its address, whatever the block's rights are.
- R4: A data read (kind 1) or a debug read (kind 2) to a block whose read right is 0 gives `rsp_rdata` equal to 0 and `rsp_err` equal to 1, for that one response cycle only. The block index is address bits [16:14].
- R5: A block with its read right at 1 and its write right at 0 still serves data and debug reads, but refuses program and erase.
- R6: A program (kind 3) or erase (kind 4) to a block whose write right is 0, issued while idle, sets raw bit 1 on the next edge and does not start an operation.
- R7: An accepted program or erase holds `busy` high for exactly PROG_CYCLES cycles. Raw bit 0 is set on the edge where `busy` falls.
- R8: A pump fault while busy ends the operation on the next edge and sets raw bit 2. Raw bit 0 is not set for that operation.
- R9: A program or erase issued while busy has no effect: it does not change the busy length or any raw flag, even when it targets a protected block.
- R10: Raw flags stay set until a 1 is written to the matching `irq_clr` bit. If a flag is set and cleared in the same cycle, the set wins.
- R11: `irq` equals the OR of the raw flags ANDed with the mask. The mask is loaded from `mask_wdata` when `mask_we` is high.
- R12: Every request of kind 0, 1 or 2 gets a response one cycle later (`rsp_valid` high for one cycle). Program, erase and the unused kinds 5 to 7 produce no response, and kinds 5 to 7 have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 fetch, 1 data read, 2 debug read, 3 program, 4 erase |
| req_addr | input | 17 | Byte address into the array |
| arr_addr | output | 17 | Address presented to the flash array stub |
| arr_rdata | input | 32 | Word returned combinationally by the array stub |
| rsp_valid | output | 1 | Read response valid |
| rsp_err | output | 1 | Read refused |
| rsp_rdata | output | 32 | Read data, zero when refused |
| prot_we | input | 1 | Protection write strobe |
| prot_sel | input | 1 | 0 selects read rights, 1 selects write rights |
| prot_wdata | input | 8 | Bits ANDed into the selected rights |
| rd_en_o | output | 8 | Current read rights, one bit per block |
| pg_en_o | output | 8 | Current write rights, one bit per block |
| pump_fault | input | 1 | Pump voltage out of specification |
| busy | output | 1 | Program or erase in progress |
| irq_clr | input | 3 | Write-1-to-clear for the raw flags |
| mask_we | input | 1 | Mask load strobe |
| mask_wdata | input | 3 | New mask value |
| raw_status | output | 3 | Raw flags: finished, access refused, pump fault |
| irq | output | 1 | Masked interrupt |

## Verification
The bench makes a block execute-only and checks that fetches from it still return array data while data and debug reads get zeros and an error. A design that tied fetches to the read right would refuse that code. It sends an erase to a protected block while an allowed program is running. A design that checked rights during busy would raise a false access flag, and one that restarted the sequence would stretch `busy`. It injects a pump fault in the middle of an erase and then waits past the normal finish time. A design that let the sequence run on would set the finished flag after all. It also clears a flag in the same cycle that a new violation sets it, to catch a design where the clear wins and drops the event. Finally it writes all 1s to the protection rights to check that a cleared right cannot come back.

// File: rtl/flash_guard_pkg.sv
`timescale 1ns/1ps
package flash_guard_pkg;

    typedef enum logic [2:0] {
        KIND_FETCH = 3'd0,
        KIND_DREAD = 3'd1,
        KIND_DBGRD = 3'd2,
        KIND_PROG  = 3'd3,
        KIND_ERASE = 3'd4
    } req_kind_e;

    localparam int IRQ_DONE = 0;
    localparam int IRQ_VIOL = 1;
    localparam int IRQ_PUMP = 2;
    localparam int IRQ_W    = 3;

endpackage

// File: rtl/fg_prot_regs.sv
`timescale 1ns/1ps
module fg_prot_regs #(
    parameter int NUM_BLK = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prot_we,
    input  logic               prot_sel,
    input  logic [NUM_BLK-1:0] prot_wdata,
    output logic [NUM_BLK-1:0] rd_en,
    output logic [NUM_BLK-1:0] pg_en
);

    typedef struct packed {
        logic [NUM_BLK-1:0] rd;
        logic [NUM_BLK-1:0] pg;
    } prot_t;

    prot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (prot_we) begin
            if (prot_sel) st_d.pg = st_q.pg & prot_wdata;
            else          st_d.rd = st_q.rd & prot_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rd <= '1;
            st_q.pg <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_en = st_q.rd;
    assign pg_en = st_q.pg;

    // R2
    prot_only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((st_q.rd & ~$past(st_q.rd)) == '0) && ((st_q.pg & ~$past(st_q.pg)) == '0)));

endmodule

// File: rtl/fg_access_check.sv
`timescale 1ns/1ps
module fg_access_check
    import flash_guard_pkg::*;
#(
    parameter int NUM_BLK = 8,
    parameter int BLK_LSB = 14,
    parameter int ADDR_W  = 17
) (
    input  logic               req_valid,
    input  logic [2:0]         req_kind,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [NUM_BLK-1:0] rd_en,
    input  logic [NUM_BLK-1:0] pg_en,
    input  logic               busy,
    output logic               is_read,
    output logic               read_ok,
    output logic               op_start,
    output logic               op_viol
);

    localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;

    logic [BLK_W-1:0] blk;
    logic             rd_right;
    logic             pg_right;
    logic             is_write;

    assign blk      = req_addr[BLK_LSB +: BLK_W];
    assign rd_right = rd_en[blk];
    assign pg_right = pg_en[blk];

    always_comb begin
        is_read  = 1'b0;
        is_write = 1'b0;
        read_ok  = 1'b0;
        if (req_valid) begin
            case (req_kind_e'(req_kind))
                KIND_FETCH: begin
                    is_read = 1'b1;
                    read_ok = 1'b1;
                end
                KIND_DREAD, KIND_DBGRD: begin
                    is_read = 1'b1;
                    read_ok = rd_right;
                end
                KIND_PROG, KIND_ERASE: is_write = 1'b1;
                default: ;
            endcase
        end
        op_start = is_write && !busy && pg_right;
        op_viol  = is_write && !busy && !pg_right;
    end

endmodule

// File: rtl/fg_prog_seq.sv
`timescale 1ns/1ps
module fg_prog_seq #(
    parameter int PROG_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pump_fault,
    output logic busy,
    output logic done,
    output logic abort
);

    localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        done  = 1'b0;
        abort = 1'b0;
        if (s_q.busy) begin
            if (pump_fault) begin
                s_d.busy = 1'b0;
                abort    = 1'b1;
            end else if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
                done     = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(PROG_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;

    // R8
    pump_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && pump_fault) |=> !s_q.busy);

endmodule

// File: rtl/fg_irq.sv
`timescale 1ns/1ps
module fg_irq
    import flash_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set,
    input  logic [IRQ_W-1:0] clr,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] mask_wdata,
    output logic [IRQ_W-1:0] raw,
    output logic             irq
);

    typedef struct packed {
        logic [IRQ_W-1:0] raw;
        logic [IRQ_W-1:0] mask;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.raw = (st_q.raw & ~clr) | set;
        if (mask_we) st_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw = st_q.raw;
    assign irq = |(st_q.raw & st_q.mask);

    // R10
    raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.raw & $past(st_q.raw & ~clr)) == $past(st_q.raw & ~clr)));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((st_q.raw & $past(set)) == $past(set)));

endmodule

// File: rtl/flash_guard.sv
`timescale 1ns/1ps
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int NUM_BLK     = 8,
    parameter int BLK_BYTES   = 16384,
    parameter int DATA_W      = 32,
    parameter int PROG_CYCLES = 4
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        req_valid,
    input  logic [2:0]                                  req_kind,
    input  logic [$clog2(BLK_BYTES)+$clog2(NUM_BLK)-1:0] req_addr,
    output logic [$clog2(BLK_BYTES)+$clog2(NUM_BLK)-1:0] arr_addr,
    input  logic [DATA_W-1:0]                           arr_rdata,
    output logic                                        rsp_valid,
    output logic                                        rsp_err,
    output logic [DATA_W-1:0]                           rsp_rdata,
    input  logic                                        prot_we,
    input  logic                                        prot_sel,
    input  logic [NUM_BLK-1:0]                          prot_wdata,
    output logic [NUM_BLK-1:0]                          rd_en_o,
    output logic [NUM_BLK-1:0]                          pg_en_o,
    input  logic                                        pump_fault,
    output logic                                        busy,
    input  logic [2:0]                                  irq_clr,
    input  logic                                        mask_we,
    input  logic [2:0]                                  mask_wdata,
    output logic [2:0]                                  raw_status,
    output logic                                        irq
);

    localparam int BLK_LSB = $clog2(BLK_BYTES);
    localparam int ADDR_W  = BLK_LSB + $clog2(NUM_BLK);

    typedef struct packed {
        logic              v;
        logic              e;
        logic [DATA_W-1:0] d;
    } rsp_t;

    logic [NUM_BLK-1:0] rd_en, pg_en;
    logic               is_read, read_ok, op_start, op_viol;
    logic               seq_done, seq_abort;
    logic [IRQ_W-1:0]   irq_set;
    rsp_t               rsp_d, rsp_q;

    fg_prot_regs #(.NUM_BLK(NUM_BLK)) u_prot (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_we   (prot_we),
        .prot_sel  (prot_sel),
        .prot_wdata(prot_wdata),
        .rd_en     (rd_en),
        .pg_en     (pg_en)
    );

    fg_access_check #(
        .NUM_BLK(NUM_BLK),
        .BLK_LSB(BLK_LSB),
        .ADDR_W (ADDR_W)
    ) u_chk (
        .req_valid(req_valid),
        .req_kind (req_kind),
        .req_addr (req_addr),
        .rd_en    (rd_en),
        .pg_en    (pg_en),
        .busy     (busy),
        .is_read  (is_read),
        .read_ok  (read_ok),
        .op_start (op_start),
        .op_viol  (op_viol)
    );

    fg_prog_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (op_start),
        .pump_fault(pump_fault),
        .busy      (busy),
        .done      (seq_done),
        .abort     (seq_abort)
    );

    always_comb begin
        irq_set           = '0;
        irq_set[IRQ_DONE] = seq_done;
        irq_set[IRQ_VIOL] = op_viol;
        irq_set[IRQ_PUMP] = seq_abort;
    end

    fg_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (irq_set),
        .clr       (irq_clr),
        .mask_we   (mask_we),
        .mask_wdata(mask_wdata),
        .raw       (raw_status),
        .irq       (irq)
    );

    assign arr_addr = req_addr;

    always_comb begin
        rsp_d   = '0;
        rsp_d.v = is_read;
        rsp_d.e = is_read && !read_ok;
        rsp_d.d = (is_read && read_ok) ? arr_rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.v;
    assign rsp_err   = rsp_q.e;
    assign rsp_rdata = rsp_q.d;
    assign rd_en_o   = rd_en;
    assign pg_en_o   = pg_en;

    // R4
    refused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    // R12
    err_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    // R6
    viol_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_viol |=> (raw_status[IRQ_VIOL] && !busy));

    // R9
    busy_no_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !raw_status[IRQ_VIOL]) |=> !raw_status[IRQ_VIOL]);

    // R8
    abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pump_fault) |=> raw_status[IRQ_PUMP]);

endmodule

// File: tb/flash_guard_bench.sv
`timescale 1ns/1ps
module flash_guard_bench;

    localparam int NB    = 8;
    localparam int AW    = 17;
    localparam int DW    = 32;
    localparam int PCYC  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_kind = '0;
    logic [AW-1:0] req_addr = '0;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_rdata;
    logic          rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          prot_we = 1'b0;
    logic          prot_sel = 1'b0;
    logic [NB-1:0] prot_wdata = '0;
    logic [NB-1:0] rd_en_o, pg_en_o;
    logic          pump_fault = 1'b0;
    logic          busy;
    logic [2:0]    irq_clr = '0;
    logic          mask_we = 1'b0;
    logic [2:0]    mask_wdata = '0;
    logic [2:0]    raw_status;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] word_at(logic [AW-1:0] a);
        return 32'hC0DE_0000 ^ {15'd0, a};
    endfunction

    assign arr_rdata = word_at(arr_addr);

    flash_guard #(
        .NUM_BLK(NB), .BLK_BYTES(16384), .DATA_W(DW), .PROG_CYCLES(PCYC)
    ) u_flash_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .prot_we(prot_we), .prot_sel(prot_sel), .prot_wdata(prot_wdata),
        .rd_en_o(rd_en_o), .pg_en_o(pg_en_o), .pump_fault(pump_fault),
        .busy(busy), .irq_clr(irq_clr), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .raw_status(raw_status), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    logic [NB-1:0] m_rd, m_pg;
    logic [2:0]    m_raw, m_mask;
    bit            m_busy;
    int            m_left;
    bit            m_v, m_e;
    logic [DW-1:0] m_d;
    int            t_blk;
    logic [2:0]    t_set;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rd = '1; m_pg = '1; m_raw = '0; m_mask = '0;
            m_busy = 0; m_left = 0; m_v = 0; m_e = 0; m_d = '0;
        end else begin
            t_blk = int'(req_addr[16:14]);
            t_set = '0;
            m_v = 0; m_e = 0; m_d = '0;
            if (req_valid && req_kind <= 3'd2) begin
                m_v = 1;
                if (req_kind == 3'd0 || m_rd[t_blk]) m_d = word_at(req_addr);
                else m_e = 1;
            end
            if (m_busy) begin
                if (pump_fault) begin
                    m_busy = 0; t_set[2] = 1'b1;
                end else if (m_left == 1) begin
                    m_busy = 0; t_set[0] = 1'b1;
                end else begin
                    m_left = m_left - 1;
                end
            end else if (req_valid && (req_kind == 3'd3 || req_kind == 3'd4)) begin
                if (m_pg[t_blk]) begin
                    m_busy = 1; m_left = PCYC;
                end else begin
                    t_set[1] = 1'b1;
                end
            end
            m_raw = (m_raw & ~irq_clr) | t_set;
            if (mask_we) m_mask = mask_wdata;
            if (prot_we) begin
                if (prot_sel) m_pg = m_pg & prot_wdata;
                else          m_rd = m_rd & prot_wdata;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R12 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_v});
            check("R4 rsp_err", {31'd0, rsp_err}, {31'd0, m_e});
            check("R3 rsp_rdata", rsp_rdata, m_d);
            check("R7 busy", {31'd0, busy}, {31'd0, m_busy});
            check("R10 raw_status", {29'd0, raw_status}, {29'd0, m_raw});
            check("R11 irq", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
            check("R2 rd_en_o", {24'd0, rd_en_o}, {24'd0, m_rd});
            check("R2 pg_en_o", {24'd0, pg_en_o}, {24'd0, m_pg});
        end
    end

    // All drive tasks start and end just after a rising edge
    task automatic issue(logic [2:0] k, logic [AW-1:0] a);
        req_valid = 1'b1; req_kind = k; req_addr = a;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic prot_write(logic sel, logic [NB-1:0] d);
        prot_we = 1'b1; prot_sel = sel; prot_wdata = d;
        @(posedge clk); #1;
        prot_we = 1'b0;
    endtask

    task automatic clear_raw(logic [2:0] c);
        irq_clr = c;
        @(posedge clk); #1;
        irq_clr = '0;
    endtask

    task automatic set_mask(logic [2:0] m);
        mask_we = 1'b1; mask_wdata = m;
        @(posedge clk); #1;
        mask_we = 1'b0;
    endtask

    localparam logic [AW-1:0] A_B0 = 17'h00100;
    localparam logic [AW-1:0] A_B1 = 17'h04000;
    localparam logic [AW-1:0] A_B2 = 17'h08010;
    localparam logic [AW-1:0] A_B3 = 17'h0C044;
    localparam logic [AW-1:0] A_B5 = 17'h14020;

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1 rd_en", {24'd0, rd_en_o}, 32'hFF);
        check("R1 pg_en", {24'd0, pg_en_o}, 32'hFF);
        check("R1 raw", {29'd0, raw_status}, 32'd0);
        check("R1 busy/irq/valid", {29'd0, busy, irq, rsp_valid}, 32'd0);

        issue(3'd0, A_B2);
        check("R3 fetch open block", rsp_rdata, word_at(A_B2));

        // R2 clear read right of block 2, then try to restore it
        prot_write(1'b0, 8'hFB);
        check("R2 clear", {24'd0, rd_en_o}, 32'hFB);
        prot_write(1'b0, 8'hFF);
        check("R2 no restore", {24'd0, rd_en_o}, 32'hFB);

        issue(3'd0, A_B2);
        check("R3 fetch execute-only", rsp_rdata, word_at(A_B2));
        check("R3 fetch no err", {31'd0, rsp_err}, 32'd0);
        issue(3'd1, A_B2);
        check("R4 data read err", {31'd0, rsp_err}, 32'd1);
        check("R4 data read zero", rsp_rdata, 32'd0);
        issue(3'd2, A_B2);
        check("R4 debug read err", {31'd0, rsp_err}, 32'd1);
        @(posedge clk); #1;
        check("R4 err one cycle", {30'd0, rsp_err, rsp_valid}, 32'd0);

        // R5 read-only block 5
        prot_write(1'b1, 8'hDF);
        issue(3'd1, A_B5);
        check("R5 data read ok", rsp_rdata, word_at(A_B5));
        issue(3'd2, A_B5);
        check("R5 debug read ok", {31'd0, rsp_err}, 32'd0);
        issue(3'd3, A_B5);
        check("R6 violation flag", {29'd0, raw_status}, 32'd2);
        check("R6 no busy", {31'd0, busy}, 32'd0);
        check("R12 no response to program", {31'd0, rsp_valid}, 32'd0);
        clear_raw(3'b010);
        check("R10 w1c", {29'd0, raw_status}, 32'd0);

        // R7 / R9 allowed program with blocked erase injected while busy
        issue(3'd3, A_B0);
        check("R7 busy starts", {31'd0, busy}, 32'd1);
        n = 0;
        req_valid = 1'b1; req_kind = 3'd4; req_addr = A_B5;
        while (busy && n < 50) begin
            @(posedge clk); #1;
            req_valid = 1'b0;
            n++;
        end
        check("R7 busy length", n, PCYC);
        check("R9 busy command ignored", {29'd0, raw_status}, 32'd1);

        // R8 pump fault aborts an erase
        clear_raw(3'b001);
        issue(3'd4, A_B1);
        @(posedge clk); #1;
        pump_fault = 1'b1;
        @(posedge clk); #1;
        pump_fault = 1'b0;
        check("R8 aborted", {31'd0, busy}, 32'd0);
        check("R8 pump flag", {29'd0, raw_status}, 32'd4);
        repeat (PCYC + 2) @(posedge clk);
        #1;
        check("R8 no finish flag", {29'd0, raw_status}, 32'd4);

        // R11 mask
        set_mask(3'b001);
        check("R11 masked off", {31'd0, irq}, 32'd0);
        set_mask(3'b100);
        check("R11 masked on", {31'd0, irq}, 32'd1);

        // R10 set beats clear in the same cycle
        irq_clr = 3'b110;
        issue(3'd3, A_B5);
        irq_clr = '0;
        check("R10 set wins", {29'd0, raw_status}, 32'd2);
        check("R11 after clear", {31'd0, irq}, 32'd0);

        // R12 unused kind
        issue(3'd5, A_B3);
        check("R12 unused kind", {28'd0, rsp_valid, raw_status}, 32'd2);

        // R3 fully locked block still fetches
        prot_write(1'b0, 8'hF7);
        prot_write(1'b1, 8'hF7);
        issue(3'd0, A_B3);
        check("R3 locked fetch", rsp_rdata, word_at(A_B3));
        issue(3'd1, A_B3);
        check("R4 locked data read", {31'd0, rsp_err}, 32'd1);

        repeat (2) @(posedge clk);
        #1;
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(64'd200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R7: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule